// File: doc/BRIEF.md
# Countdown Event Timer

A single-channel countdown timer behind a small register bus, used to raise one interrupt after a chosen number of ticks. Software enables the block and writes a tick count. That write loads the counter and starts it. Software then turns on the interrupt. The counter moves down by one for each pulse on the tick input. When it reaches zero, the block raises a sticky expired condition and stops. The interrupt line is a level signal. It stays high until software writes the clear bit or loads a new count.

The block has two words. A control word sits at byte offset 0x40 and a count word at 0x44. A write of all zeros to the control word parks the timer. While the enable bit is clear, count loads and interrupt-enable changes are dropped. Reads return data in the same cycle the address is presented.

Top module: `evt_countdown_timer`

## Requirements
- R1: After reset, the control word (offset 0x40) reads 0, the count word (offset 0x44) reads 0, and `irq` is low.
- R2: A write to the count word while control bit 0 (enable) is clear has no effect. The count word keeps its previous value.
- R3: Control bit 1 (interrupt enable) only changes on a control write made while enable is already set. When enable is turned on from off, bit 1 of that same write is dropped.
- R4: A count write made while enable is set loads the counter and starts it. The count word then reads the loaded value. Each later cycle with `tick_en` high lowers the count by exactly 1.
- R5: A loaded value below 3 is raised to 3. Any value from 3 up to 0xFFFFFFFF is loaded unchanged.
- R6: When the count reaches 0, the expired condition is set and counting stops. Further ticks leave the count at 0 and the condition stays set.
- R7: `irq` is high exactly when the expired condition is set and control bit 1 is set.
- R8: Writing 1 to control bit 4 clears the expired condition. Bit 4 always reads as 0. If expiry happens in the same cycle as the clear, the expiry wins.
- R9: A control write with bit 0 clear stops counting at once, including a tick in that same cycle. It also clears bit 1. The count word keeps its value.
- R10: In a cycle without `tick_en` and without a count write, the count word does not change.
- R11: A new accepted count write clears a pending expired condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Countdown step pulse, one decrement per high cycle |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, valid in the cycle of a read access |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, an 8-bit address and a floor of 3 ticks. Short loads of 0, 1, 3, 7, 10 and 25 ticks reach expiry within a few dozen cycles. This covers the clamping floor, the exact tick of expiry and the sticky behaviour after it. A directed load of 0xFFFFFFFF checks the top of the range without running it down.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

  // Control word bit positions; software decodes these.
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_IE_BIT  = 1;
  localparam int unsigned CTRL_CLR_BIT = 4;

  // Commands from the register decode to the counter, valid one cycle.
  typedef struct packed {
    logic load;   // accepted count write
    logic halt;   // control write with enable cleared
    logic clr;    // write-one clear of expired condition
  } tmr_cmd_t;

endpackage

// File: rtl/evt_tmr_rst_sync.sv
module evt_tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
  import evt_tmr_pkg::*;
#(
  parameter int unsigned            ADDR_W    = 8,
  parameter int unsigned            CNT_W     = 32,
  parameter logic [ADDR_W-1:0]      CTRL_OFS  = 8'h40,
  parameter logic [ADDR_W-1:0]      VAL_OFS   = 8'h44,
  parameter int unsigned            MIN_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              en,
  output logic              irq_en,
  output tmr_cmd_t          cmd,
  output logic [CNT_W-1:0]  load_val
);

  localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(MIN_TICKS);

  logic en_q, en_d;
  logic ie_q, ie_d;
  logic hit_ctrl, hit_val;
  logic wr_ctrl, wr_val, rd_any;

  assign hit_ctrl = (bus_addr == CTRL_OFS);
  assign hit_val  = (bus_addr == VAL_OFS);
  assign wr_ctrl  = bus_sel & bus_wr & hit_ctrl;
  assign wr_val   = bus_sel & bus_wr & hit_val;
  assign rd_any   = bus_sel & ~bus_wr;

  // Next state of the control bits.
  always_comb begin
    en_d = en_q;
    ie_d = ie_q;
    if (wr_ctrl) begin
      en_d = bus_wdata[CTRL_EN_BIT];
      if (!bus_wdata[CTRL_EN_BIT]) begin
        ie_d = 1'b0;
      end else if (en_q) begin
        ie_d = bus_wdata[CTRL_IE_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else begin
      en_q <= en_d;
      ie_q <= ie_d;
    end
  end

  // Commands for the counter.
  always_comb begin
    cmd.load = wr_val & en_q;
    cmd.halt = wr_ctrl & ~bus_wdata[CTRL_EN_BIT];
    cmd.clr  = wr_ctrl & bus_wdata[CTRL_CLR_BIT];
    load_val = (bus_wdata < MIN_VAL) ? MIN_VAL : bus_wdata;
  end

  // Read mux; clear bit reads as zero.
  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      if (hit_ctrl) begin
        bus_rdata[CTRL_EN_BIT] = en_q;
        bus_rdata[CTRL_IE_BIT] = ie_q;
      end else if (hit_val) begin
        bus_rdata = count;
      end
    end
  end

  assign en     = en_q;
  assign irq_en = ie_q;

endmodule

// File: rtl/evt_tmr_counter.sv
module evt_tmr_counter
  import evt_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick_en,
  input  tmr_cmd_t         cmd,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expired,
  output logic             running
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             exp_q, exp_d;
  logic             step;

  assign step = en & run_q & tick_en;

  // Priority: halt over load over step; a set from expiry beats a clear.
  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    exp_d = exp_q;
    if (cmd.clr) begin
      exp_d = 1'b0;
    end
    if (cmd.halt) begin
      run_d = 1'b0;
    end else if (cmd.load) begin
      cnt_d = load_val;
      run_d = 1'b1;
      exp_d = 1'b0;
    end else if (step) begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) begin
        run_d = 1'b0;
        exp_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      exp_q <= exp_d;
    end
  end

  assign count   = cnt_q;
  assign expired = exp_q;
  assign running = run_q;

endmodule

// File: rtl/evt_countdown_timer.sv
module evt_countdown_timer
  import evt_tmr_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       CNT_W     = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'h40,
  parameter logic [ADDR_W-1:0] VAL_OFS   = 8'h44,
  parameter int unsigned       MIN_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);

  logic             rst_n_sync;
  logic             en, irq_en, expired, running;
  tmr_cmd_t         cmd;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count;

  evt_tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  evt_tmr_regs #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .CTRL_OFS  (CTRL_OFS),
    .VAL_OFS   (VAL_OFS),
    .MIN_TICKS (MIN_TICKS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count     (count),
    .bus_rdata (bus_rdata),
    .en        (en),
    .irq_en    (irq_en),
    .cmd       (cmd),
    .load_val  (load_val)
  );

  evt_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .en       (en),
    .tick_en  (tick_en),
    .cmd      (cmd),
    .load_val (load_val),
    .count    (count),
    .expired  (expired),
    .running  (running)
  );

  assign irq = expired & irq_en;

endmodule

// File: rtl/evt_tmr_checker.sv
module evt_tmr_checker
  import evt_tmr_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned MIN_TICKS = 3
) (
  input logic             clk,
  input logic             rst_n_sync,
  input logic             tick_en,
  input logic             en,
  input logic             irq_en,
  input logic             expired,
  input logic             running,
  input logic             irq,
  input tmr_cmd_t         cmd,
  input logic [CNT_W-1:0] count
);

  // R10: quiet cycle leaves the count alone
  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!tick_en && !cmd.load) |=> $stable(count));

  // R2: nothing moves the count while disabled
  p_disabled_hold_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !en |=> $stable(count));

  // R4: a tick on a running, enabled counter steps it down by one
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (en && running && tick_en && !cmd.load && !cmd.halt)
      |=> (count == $past(count) - CNT_W'(1)));

  // R5: every accepted load is at least the floor
  p_min_load_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cmd.load && !cmd.halt) |=> (count >= CNT_W'(MIN_TICKS)));

  // R6: expiry only at zero, and the counter stops
  p_expire_zero_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(expired) |-> (count == '0 && !running));

  // R6: expired is sticky until cleared or reloaded
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (expired && !cmd.clr && !cmd.load) |=> expired);

  // R7: interrupt requires both the condition and the enable
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    irq |-> (expired && irq_en && en));

  // R9: a halt stops counting on the next cycle
  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cmd.halt |=> (!running && !irq_en && $stable(count)));

endmodule

bind evt_countdown_timer evt_tmr_checker #(
  .CNT_W     (CNT_W),
  .MIN_TICKS (MIN_TICKS)
) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .tick_en    (tick_en),
  .en         (en),
  .irq_en     (irq_en),
  .expired    (expired),
  .running    (running),
  .irq        (irq),
  .cmd        (cmd),
  .count      (count)
);

// File: tb/evt_countdown_timer_bench.sv
module evt_countdown_timer_bench;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned CNT_W  = 32;
  localparam logic [7:0]  A_CTRL = 8'h40;
  localparam logic [7:0]  A_VAL  = 8'h44;

  // {value written, expected loaded count}
  localparam int NVEC = 6;
  localparam logic [63:0] VEC [NVEC] = '{
    {32'd10, 32'd10},
    {32'd1,  32'd3},
    {32'd0,  32'd3},
    {32'd3,  32'd3},
    {32'd7,  32'd7},
    {32'd25, 32'd25}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tick_en;
  logic              bus_sel, bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [CNT_W-1:0]  bus_wdata;
  logic [CNT_W-1:0]  bus_rdata;
  logic              irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_countdown_timer u_evt_countdown_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    rd(A_VAL, d);  check("R1 count", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 count write while disabled is dropped
    wr(A_VAL, 32'd50);
    rd(A_VAL, d); check("R2 count", d, 32'h0);

    // R3 interrupt enable dropped when enabling from off
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, d); check("R3 ctrl", d, 32'h1);

    // Table: load, count down, expire, clear (R4 R5 R6 R7 R8)
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] w, e;
      w = VEC[v][63:32]; e = VEC[v][31:0];
      wr(A_CTRL, 32'h1);
      wr(A_VAL, w);
      wr(A_CTRL, 32'h3);
      rd(A_VAL, d); check("R5 loaded count", d, e);
      ticks(int'(e) - 1);
      rd(A_VAL, d); check("R4 count before last tick", d, 32'd1);
      check("R7 irq before expiry", {31'b0, irq}, 32'h0);
      ticks(1);
      check("R6 irq at expiry", {31'b0, irq}, 32'h1);
      rd(A_VAL, d); check("R6 count at zero", d, 32'h0);
      wr(A_CTRL, 32'h13);
      check("R8 irq after clear", {31'b0, irq}, 32'h0);
      rd(A_CTRL, d); check("R8 clear bit reads zero", d, 32'h3);
    end

    // R6 sticky after expiry, further ticks do nothing
    wr(A_VAL, 32'd3);
    ticks(5);
    rd(A_VAL, d); check("R6 stays at zero", d, 32'h0);
    check("R6 irq sticky", {31'b0, irq}, 32'h1);

    // R7 interrupt enable off masks the line, on reveals it
    wr(A_CTRL, 32'h1);
    check("R7 masked", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h3);
    check("R7 unmasked", {31'b0, irq}, 32'h1);

    // R11 new load clears the pending condition
    wr(A_VAL, 32'd8);
    check("R11 irq after reload", {31'b0, irq}, 32'h0);

    // R10 no tick, no change
    repeat (6) @(negedge clk);
    rd(A_VAL, d); check("R10 hold", d, 32'd8);

    // R9 stop by writing zero, tick in the same cycle ignored
    ticks(2);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h0; tick_en = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
    rd(A_VAL, d); check("R9 count frozen", d, 32'd6);
    rd(A_CTRL, d); check("R9 ctrl cleared", d, 32'h0);
    ticks(3);
    rd(A_VAL, d); check("R9 no count after stop", d, 32'd6);

    // R8 expiry in same cycle as clear: expiry wins
    wr(A_CTRL, 32'h1);
    wr(A_VAL, 32'd3);
    wr(A_CTRL, 32'h3);
    ticks(2);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h13; tick_en = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
    check("R8 expiry beats clear", {31'b0, irq}, 32'h1);

    // R5 top of range loads unchanged, R4 steps down
    wr(A_VAL, 32'hFFFF_FFFF);
    rd(A_VAL, d); check("R5 max load", d, 32'hFFFF_FFFF);
    ticks(2);
    rd(A_VAL, d); check("R4 max minus two", d, 32'hFFFF_FFFD);

    finish_run();
  end

endmodule